// File: doc/BRIEF.md
# ASCII Parameter Entry Decoder

This block keeps a small set of user fitness parameters: age, sex, body weight, aerobic capacity, daily calorie intake and desired calorie deficit. A keypad or terminal front end presents a complete five-character ASCII word on a parallel bus and raises a load strobe for one clock. The leading character selects which parameter the word addresses. The other four characters carry a decimal value, which the block converts to a 14-bit binary number and writes into the selected register.

A word is accepted only when all five characters are decimal digits. Otherwise the whole word is dropped. One selector code puts every parameter back to its default value, and the reset input does the same. Age, weight and aerobic capacity each have an upper limit, and a value above that limit is stored as the limit. Every parameter is presented as a registered 14-bit output for downstream computation logic.

Top module: `param_entry_decoder`

## Requirements
- R1: While reset is asserted, the outputs hold age 20, sex 0, weight 135, aerobic capacity 40, calorie intake 2000 and deficit 100.
- R2: Character k sits in word bits 7k+6 down to 7k. Character 4 is the selector. Characters 3, 2, 1 and 0 are the thousands, hundreds, tens and units digits. A character is a digit only when its upper three bits are 011 and its lower four bits hold a value from 0 to 9. That lower nibble is the digit value.
- R3: If any of the five characters is not a digit, including a character such as ':' whose upper bits are 011 but whose nibble is above 9, no output changes.
- R4: A word is acted on only at a rising clock edge where the load strobe is high. With the strobe low, the outputs do not change.
- R5: Selector 0 writes age. Values above 126 are stored as 126.
- R6: Selector 1 writes sex. The stored value is the least significant bit of the decoded value, so the output is 0 or 1.
- R7: Selector 2 writes weight. Values above 510 are stored as 510.
- R8: Selector 3 writes aerobic capacity. Values above 254 are stored as 254.
- R9: Selector 4 writes calorie intake and selector 5 writes desired deficit. Both take any value from 0 to 9999 unchanged.
- R10: Selector 6 restores all six parameters to the R1 defaults. The value digits play no part.
- R11: Selectors 7, 8 and 9 change nothing.
- R12: An accepted write shows on the outputs right after the clock edge where the strobe was sampled. Only the selected parameter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | Load strobe for the word on word_i |
| word_i | input | 35 | Five 7-bit ASCII characters; character 4 is the selector |
| age_o | output | 14 | Stored age |
| sex_o | output | 14 | Stored sex flag (0 or 1) |
| weight_o | output | 14 | Stored weight |
| vo2_o | output | 14 | Stored aerobic capacity |
| intake_o | output | 14 | Stored daily calorie intake |
| deficit_o | output | 14 | Stored desired deficit |

## Verification
The assertions check four things on every cycle. Outputs hold still without a strobe. Outputs hold still when a strobed word has a non-digit character. The clamped parameters never go past their limits. The sex output is only ever 0 or 1. The assertions also check that a strobed restore word is followed by the default values. Only the bench scenarios can show the rest. These cover the exact decimal-to-binary values, that a write reaches the addressed register and leaves the others alone, that selectors 7 to 9 are ignored, and the defaults coming back after reset is asserted in the middle of a run.

// File: rtl/param_entry_pkg.sv
package param_entry_pkg;
  localparam int CHAR_W     = 7;
  localparam int NUM_CHARS  = 5;
  localparam int NUM_VDIG   = NUM_CHARS - 1;
  localparam int WORD_W     = CHAR_W * NUM_CHARS;
  localparam int VAL_W      = 14;
  localparam int SEL_CHAR   = NUM_CHARS - 1;

  localparam logic [3:0] SEL_AGE     = 4'd0;
  localparam logic [3:0] SEL_SEX     = 4'd1;
  localparam logic [3:0] SEL_WEIGHT  = 4'd2;
  localparam logic [3:0] SEL_VO2     = 4'd3;
  localparam logic [3:0] SEL_INTAKE  = 4'd4;
  localparam logic [3:0] SEL_DEFICIT = 4'd5;
  localparam logic [3:0] SEL_RESTORE = 4'd6;

  localparam logic [VAL_W-1:0] AGE_MAX    = VAL_W'(126);
  localparam logic [VAL_W-1:0] WEIGHT_MAX = VAL_W'(510);
  localparam logic [VAL_W-1:0] VO2_MAX    = VAL_W'(254);

  typedef struct packed {
    logic [VAL_W-1:0] age;
    logic [VAL_W-1:0] sex;
    logic [VAL_W-1:0] weight;
    logic [VAL_W-1:0] vo2;
    logic [VAL_W-1:0] intake;
    logic [VAL_W-1:0] deficit;
  } params_t;

  function automatic params_t default_params();
    params_t p;
    p.age     = VAL_W'(20);
    p.sex     = VAL_W'(0);
    p.weight  = VAL_W'(135);
    p.vo2     = VAL_W'(40);
    p.intake  = VAL_W'(2000);
    p.deficit = VAL_W'(100);
    return p;
  endfunction

  function automatic logic [VAL_W-1:0] clamp_to(input logic [VAL_W-1:0] v,
                                                input logic [VAL_W-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction
endpackage

// File: rtl/ascii_char_decode.sv
module ascii_char_decode #(
  parameter int CHAR_W = 7
) (
  input  logic [CHAR_W-1:0] char_i,
  output logic              is_digit_o,
  output logic [3:0]        digit_o
);
  logic zone_ok;
  always_comb begin
    zone_ok    = (char_i[CHAR_W-1:4] == 3'b011);
    digit_o    = char_i[3:0];
    is_digit_o = zone_ok && (char_i[3:0] <= 4'd9);
  end
endmodule

// File: rtl/digit_combiner.sv
module digit_combiner #(
  parameter int NUM_DIGITS = 4,
  parameter int VAL_W      = 14
) (
  input  logic [NUM_DIGITS*4-1:0] digits_i,
  output logic [VAL_W-1:0]        value_o
);
  always_comb begin
    value_o = '0;
    for (int i = NUM_DIGITS - 1; i >= 0; i--) begin
      value_o = VAL_W'((value_o << 3) + (value_o << 1)) + VAL_W'(digits_i[i*4 +: 4]);
    end
  end
endmodule

// File: rtl/param_bank.sv
module param_bank
  import param_entry_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [3:0]       sel_i,
  input  logic [VAL_W-1:0] value_i,
  output params_t          params_o
);
  params_t params_q, params_d;

  always_comb begin
    params_d = params_q;
    if (wr_en_i) begin
      case (sel_i)
        SEL_AGE:     params_d.age     = clamp_to(value_i, AGE_MAX);
        SEL_SEX:     params_d.sex     = VAL_W'(value_i[0]);
        SEL_WEIGHT:  params_d.weight  = clamp_to(value_i, WEIGHT_MAX);
        SEL_VO2:     params_d.vo2     = clamp_to(value_i, VO2_MAX);
        SEL_INTAKE:  params_d.intake  = value_i;
        SEL_DEFICIT: params_d.deficit = value_i;
        SEL_RESTORE: params_d         = default_params();
        default:     params_d         = params_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) params_q <= default_params();
    else         params_q <= params_d;
  end

  assign params_o = params_q;
endmodule

// File: rtl/param_entry_decoder.sv
module param_entry_decoder
  import param_entry_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [VAL_W-1:0]  age_o,
  output logic [VAL_W-1:0]  sex_o,
  output logic [VAL_W-1:0]  weight_o,
  output logic [VAL_W-1:0]  vo2_o,
  output logic [VAL_W-1:0]  intake_o,
  output logic [VAL_W-1:0]  deficit_o
);
  logic [1:0]           rst_sync_q;
  logic                 rst_n_int;
  logic [NUM_CHARS-1:0] char_ok;
  logic [NUM_CHARS*4-1:0] char_val;
  logic                 word_ok;
  logic                 wr_en;
  logic [VAL_W-1:0]     value;
  params_t              params;

  // reset: assert asynchronously, release after two clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  for (genvar k = 0; k < NUM_CHARS; k++) begin : g_char
    ascii_char_decode #(.CHAR_W(CHAR_W)) u_char (
      .char_i     (word_i[k*CHAR_W +: CHAR_W]),
      .is_digit_o (char_ok[k]),
      .digit_o    (char_val[k*4 +: 4])
    );
  end

  assign word_ok = &char_ok;
  assign wr_en   = load_i && word_ok;

  digit_combiner #(.NUM_DIGITS(NUM_VDIG), .VAL_W(VAL_W)) u_comb (
    .digits_i (char_val[NUM_VDIG*4-1:0]),
    .value_o  (value)
  );

  param_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .wr_en_i  (wr_en),
    .sel_i    (char_val[SEL_CHAR*4 +: 4]),
    .value_i  (value),
    .params_o (params)
  );

  assign age_o     = params.age;
  assign sex_o     = params.sex;
  assign weight_o  = params.weight;
  assign vo2_o     = params.vo2;
  assign intake_o  = params.intake;
  assign deficit_o = params.deficit;
endmodule

// File: rtl/param_entry_checker.sv
module param_entry_checker
  import param_entry_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [WORD_W-1:0] word_i,
  input logic [VAL_W-1:0]  age_o,
  input logic [VAL_W-1:0]  sex_o,
  input logic [VAL_W-1:0]  weight_o,
  input logic [VAL_W-1:0]  vo2_o,
  input logic [VAL_W-1:0]  intake_o,
  input logic [VAL_W-1:0]  deficit_o
);
  logic [6*VAL_W-1:0] all_out;
  logic               bad_char;
  logic               is_restore;
  assign all_out = {age_o, sex_o, weight_o, vo2_o, intake_o, deficit_o};

  always_comb begin
    bad_char = 1'b0;
    for (int k = 0; k < NUM_CHARS; k++) begin
      if (word_i[k*CHAR_W+4 +: 3] != 3'b011 || word_i[k*CHAR_W +: 4] > 4'd9)
        bad_char = 1'b1;
    end
    is_restore = !bad_char && (word_i[SEL_CHAR*CHAR_W +: 4] == SEL_RESTORE);
  end

  AST_HOLD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(all_out)); // R4
  AST_REJECT_BAD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && bad_char) |=> $stable(all_out)); // R3
  AST_AGE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_o <= AGE_MAX); // R5
  AST_SEX_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sex_o <= VAL_W'(1)); // R6
  AST_WEIGHT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    weight_o <= WEIGHT_MAX); // R7
  AST_VO2_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vo2_o <= VO2_MAX); // R8
  AST_RESTORE_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && is_restore && $past(rst_ni) && rst_ni) |=>
      (age_o == 20 && sex_o == 0 && weight_o == 135 && vo2_o == 40 &&
       intake_o == 2000 && deficit_o == 100)); // R10
endmodule

bind param_entry_decoder param_entry_checker u_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .word_i    (word_i),
  .age_o     (age_o),
  .sex_o     (sex_o),
  .weight_o  (weight_o),
  .vo2_o     (vo2_o),
  .intake_o  (intake_o),
  .deficit_o (deficit_o)
);

// File: tb/param_entry_decoder_tb_top.sv
module param_entry_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [34:0] word = '0;
  logic [13:0] age, sex, weight, vo2, intake, deficit;
  int checks = 0;
  int errors = 0;
  logic [13:0] e_age, e_sex, e_weight, e_vo2, e_intake, e_deficit;

  always #4 clk = ~clk;

  param_entry_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .word_i(word),
    .age_o(age), .sex_o(sex), .weight_o(weight), .vo2_o(vo2),
    .intake_o(intake), .deficit_o(deficit)
  );

  function automatic logic [34:0] mk(input int sel, input int val);
    logic [34:0] w;
    w[34:28] = 7'h30 + 7'(sel);
    w[27:21] = 7'h30 + 7'((val / 1000) % 10);
    w[20:14] = 7'h30 + 7'((val / 100) % 10);
    w[13:7]  = 7'h30 + 7'((val / 10) % 10);
    w[6:0]   = 7'h30 + 7'(val % 10);
    return w;
  endfunction

  task automatic set_defaults();
    e_age = 20; e_sex = 0; e_weight = 135; e_vo2 = 40; e_intake = 2000; e_deficit = 100;
  endtask

  task automatic chk(input string tag, input string nm, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, nm, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "age", age, e_age);
    chk(tag, "sex", sex, e_sex);
    chk(tag, "weight", weight, e_weight);
    chk(tag, "vo2", vo2, e_vo2);
    chk(tag, "intake", intake, e_intake);
    chk(tag, "deficit", deficit, e_deficit);
  endtask

  // drive one strobed word; outputs updated at the posedge in between
  task automatic send(input logic [34:0] w, input logic ld);
    @(negedge clk);
    word = w; load = ld;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic t_reset();
    set_defaults();
    check_all("R1");
  endtask

  task automatic t_age();
    send(mk(0, 35), 1'b1); e_age = 35; check_all("R12 age write");
    send(mk(0, 126), 1'b1); e_age = 126; check_all("R5 at limit");
    send(mk(0, 200), 1'b1); e_age = 126; check_all("R5 clamp");
  endtask

  task automatic t_sex();
    send(mk(1, 7), 1'b1); e_sex = 1; check_all("R6 odd");
    send(mk(1, 4), 1'b1); e_sex = 0; check_all("R6 even");
  endtask

  task automatic t_weight_vo2();
    send(mk(2, 510), 1'b1); e_weight = 510; check_all("R7 at limit");
    send(mk(2, 999), 1'b1); e_weight = 510; check_all("R7 clamp");
    send(mk(3, 254), 1'b1); e_vo2 = 254; check_all("R8 at limit");
    send(mk(3, 300), 1'b1); e_vo2 = 254; check_all("R8 clamp");
    send(mk(3, 57), 1'b1); e_vo2 = 57; check_all("R8 small");
  endtask

  task automatic t_intake_deficit();
    send(mk(4, 9999), 1'b1); e_intake = 9999; check_all("R9 intake max");
    send(mk(4, 1234), 1'b1); e_intake = 1234; check_all("R2 R9 digit order");
    send(mk(5, 0), 1'b1); e_deficit = 0; check_all("R9 deficit zero");
    send(mk(5, 8075), 1'b1); e_deficit = 8075; check_all("R9 deficit");
  endtask

  task automatic t_reject();
    logic [34:0] w;
    w = mk(0, 12); w[13:7] = 7'h41; send(w, 1'b1); check_all("R3 letter");
    w = mk(4, 555); w[6:0] = 7'h3A; send(w, 1'b1); check_all("R3 colon");
    w = mk(2, 77); w[34:28] = 7'h20; send(w, 1'b1); check_all("R3 selector space");
    send(mk(0, 99), 1'b0); check_all("R4 no strobe");
    for (int s = 7; s <= 9; s++) begin
      send(mk(s, 1), 1'b1); check_all("R11 unused selector");
    end
  endtask

  task automatic t_restore();
    send(mk(6, 4321), 1'b1); set_defaults(); check_all("R10 restore");
  endtask

  task automatic t_async_reset();
    send(mk(4, 3333), 1'b1); e_intake = 3333; check_all("R12 before reset");
    @(negedge clk); rst_n = 1'b0;
    #1; set_defaults(); check_all("R1 async reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after release");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_age();
    t_sex();
    t_weight_vo2();
    t_intake_deficit();
    t_reject();
    t_restore();
    t_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule